// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It steers three analog switches around an external integrator: one that shorts the integrating capacitor (auto-zero), one that connects the unknown voltage, and one that connects the opposite-polarity reference. The only analog feedback it receives is a single comparator bit, high while the integrator output is above zero. A conversion starts with a start pulse. The capacitor is first shorted for a programmable number of cycles. The unknown input is then integrated for a fixed number of clock ticks. After that the reference is switched in and the block counts clock ticks until the comparator reports that the capacitor has crossed back through zero. That count is the conversion result.

The comparator is asynchronous to the block clock, so it passes through a two-flop synchronizer before the counter uses it. If no zero crossing arrives before the counter reaches its top value, the block stops, saturates the result and raises an overrange flag. A conversion therefore never hangs. Results are not delivered as a stream. The result and flag registers load together with a one-cycle done strobe and then hold until the next conversion ends. There is no back-pressure: a consumer that misses the strobe can still read the held value at any time before the next strobe. Total latency is the auto-zero length plus the fixed integrate length plus the measured count plus two cycles.

Top module: `dsadc_top`

## Requirements
- R1: While reset is held and in the first cycle after it, az_short_o, sel_in_o, sel_ref_o, busy_o, done_o and ovr_o are 0 and result_o is 0.
- R2: start_i is sampled only when the block is idle. A start pulse during a conversion has no effect on switch timing, on the result or on the flag.
- R3: After an accepted start, az_short_o is high for exactly az_len_i cycles, with az_len_i sampled at start. When az_len_i is 0 the auto-zero phase is skipped.
- R4: sel_in_o is high for exactly INT_TICKS consecutive cycles, starting immediately after auto-zero (or immediately after start when auto-zero is skipped).
- R5: sel_ref_o rises in the cycle right after sel_in_o falls. The discharge counter starts at 0 in that first cycle and advances by one per cycle. result_o equals the counter value in the cycle the phase stops, so sel_ref_o is high for result_o+1 cycles.
- R6: cmp_i reaches the stop decision through two flops. The discharge phase stops in the first cycle in which the synchronized comparator is 0. With an integrator whose level is K at the start of discharge and falls by one per cycle, the result is K+2 (0 when the level never rose above zero).
- R7: If the counter reaches 2^CNT_W-1 and the synchronized comparator is still 1, the phase stops, result_o becomes 2^CNT_W-1 and ovr_o becomes 1. A comparator of 0 in that same cycle counts as a normal stop (ovr_o 0).
- R8: done_o is high for exactly one cycle per conversion. result_o and ovr_o change only at the edge that raises done_o, and they hold their values until the next done_o.
- R9: At most one of az_short_o, sel_in_o and sel_ref_o is high in any cycle.
- R10: busy_o is high from the cycle after an accepted start through the done_o cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| az_len_i | input | AZ_W | Auto-zero length in cycles, sampled at start |
| cmp_i | input | 1 | Asynchronous comparator, 1 = integrator above zero |
| az_short_o | output | 1 | Capacitor short switch |
| sel_in_o | output | 1 | Unknown-input switch |
| sel_ref_o | output | 1 | Reference switch |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ovr_o | output | 1 | Overrange flag of the last conversion |
| result_o | output | CNT_W | Discharge count of the last conversion |

## Verification
The hardest case to reach is the stop decision at the exact moment the counter saturates, together with runs where the integrator does not start from zero. The bench models the integrator as a signed level that rises by the input step while the input switch is closed, falls by one while the reference switch is closed, and clears while the short is applied. It sweeps input steps from 0 past the overrange point with several auto-zero lengths. Runs with a zero auto-zero length start from the residue left by the previous run, which exercises the synchronizer lag at the phase boundary with negative and positive start levels. Start pulses are also injected during the integrate and discharge phases.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ZERO  = 3'd1,
    ST_INTEG = 3'd2,
    ST_DEINT = 3'd3,
    ST_DONE  = 3'd4
  } dsadc_state_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int AZ_W      = 4,
  parameter int INT_TICKS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AZ_W-1:0] az_len_i,
  input  logic            stop_i,
  output dsadc_state_e    state_o
);
  localparam int IW = (INT_TICKS > 1) ? $clog2(INT_TICKS) : 1;
  localparam logic [IW-1:0] ILAST = IW'(INT_TICKS - 1);

  dsadc_state_e    state_q;
  logic [AZ_W-1:0] zcnt_q;
  logic [IW-1:0]   icnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      zcnt_q  <= '0;
      icnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            icnt_q <= '0;
            if (az_len_i != '0) begin
              zcnt_q  <= az_len_i;
              state_q <= ST_ZERO;
            end else begin
              state_q <= ST_INTEG;
            end
          end
        end
        ST_ZERO: begin
          if (zcnt_q == AZ_W'(1)) state_q <= ST_INTEG;
          else                    zcnt_q  <= zcnt_q - AZ_W'(1);
        end
        ST_INTEG: begin
          if (icnt_q == ILAST) state_q <= ST_DEINT;
          else                 icnt_q  <= icnt_q + IW'(1);
        end
        ST_DEINT: begin
          if (stop_i) state_q <= ST_DONE;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dsadc_meas.sv
module dsadc_meas #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deint_i,
  input  logic             cmp_sync_i,
  output logic             stop_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             crossed;
  logic             at_top;

  assign crossed = !cmp_sync_i;
  assign at_top  = (cnt_q == CMAX);
  assign stop_o  = deint_i && (crossed || at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      done_o   <= 1'b0;
      ovr_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= stop_o;
      if (!deint_i || stop_o) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CNT_W'(1);
      if (stop_o) begin
        result_o <= cnt_q;
        ovr_o    <= !crossed;
      end
    end
  end
endmodule

// File: rtl/dsadc_top.sv
module dsadc_top
  import dsadc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int AZ_W      = 4,
  parameter int INT_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AZ_W-1:0]  az_len_i,
  input  logic             cmp_i,
  output logic             az_short_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [CNT_W-1:0] result_o
);
  dsadc_state_e state;
  logic         cmp_sync;
  logic         stop;
  logic         deint;

  dsadc_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_sync)
  );

  dsadc_seq #(.AZ_W(AZ_W), .INT_TICKS(INT_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .az_len_i (az_len_i),
    .stop_i   (stop),
    .state_o  (state)
  );

  assign deint = (state == ST_DEINT);

  dsadc_meas #(.CNT_W(CNT_W)) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .deint_i    (deint),
    .cmp_sync_i (cmp_sync),
    .stop_o     (stop),
    .done_o     (done_o),
    .ovr_o      (ovr_o),
    .result_o   (result_o)
  );

  assign az_short_o = (state == ST_ZERO);
  assign sel_in_o   = (state == ST_INTEG);
  assign sel_ref_o  = deint;
  assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/dsadc_chk.sv
module dsadc_chk #(
  parameter int CNT_W     = 8,
  parameter int INT_TICKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             az_short_o,
  input logic             sel_in_o,
  input logic             sel_ref_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [CNT_W-1:0] result_o
);
  localparam int RW = $clog2(INT_TICKS + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (sel_in_o) run_q <= run_q + RW'(1);
    else               run_q <= '0;
  end

  assert_switch_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({az_short_o, sel_in_o, sel_ref_o}));

  assert_integ_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_in_o |-> (run_q < RW'(INT_TICKS)));

  assert_integ_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_in_o) |-> (run_q == RW'(INT_TICKS)));

  assert_ref_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_o) |-> $past(sel_in_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

  assert_ovr_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovr_o) |-> (result_o == {CNT_W{1'b1}}));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
endmodule

bind dsadc_top dsadc_chk #(.CNT_W(CNT_W), .INT_TICKS(INT_TICKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .az_short_o (az_short_o),
  .sel_in_o   (sel_in_o),
  .sel_ref_o  (sel_ref_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ovr_o      (ovr_o),
  .result_o   (result_o)
);

// File: tb/sim_dsadc_top.sv
module sim_dsadc_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int AZ_W       = 3;
  localparam int INT_TICKS  = 8;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [AZ_W-1:0]  az_len_i = '0;
  logic             cmp_i;
  logic             az_short_o, sel_in_o, sel_ref_o, busy_o, done_o, ovr_o;
  logic [CNT_W-1:0] result_o;

  int total = 0;
  int bad   = 0;
  int acc   = 0;
  int vin   = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsadc_top #(.CNT_W(CNT_W), .AZ_W(AZ_W), .INT_TICKS(INT_TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .az_len_i(az_len_i),
    .cmp_i(cmp_i), .az_short_o(az_short_o), .sel_in_o(sel_in_o),
    .sel_ref_o(sel_ref_o), .busy_o(busy_o), .done_o(done_o),
    .ovr_o(ovr_o), .result_o(result_o)
  );

  // behavioural integrator: input step per cycle, reference step of one
  always @(posedge clk) begin
    if (az_short_o)     acc <= 0;
    else if (sel_in_o)  acc <= acc + vin;
    else if (sel_ref_o) acc <= acc - 1;
  end
  assign cmp_i = (acc > 0);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected stop cycle from the two-cycle comparator lag
  function automatic int exp_count(input int a0, input int v, output bit ov);
    int k = a0 + INT_TICKS * v;
    for (int j = 0; j <= CMAX; j++) begin
      bit s;
      if (j == 0)      s = (a0 + (INT_TICKS - 2) * v) > 0;
      else if (j == 1) s = (a0 + (INT_TICKS - 1) * v) > 0;
      else             s = (k - (j - 2)) > 0;
      if (!s) begin ov = 0; return j; end
    end
    ov = 1;
    return CMAX;
  endfunction

  task automatic convert(input int v, input int az, input bit poke);
    int n_az = 0, n_in = 0, n_ref = 0, cyc = 0, a0, e;
    int old_res;
    bit e_ov;
    bit seen = 0;
    vin = v;
    @(negedge clk);
    a0 = (az != 0) ? 0 : acc;
    e = exp_count(a0, v, e_ov);
    old_res = result_o;
    az_len_i = AZ_W'(az);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10 busy after start", busy_o, 1);
    while (!seen && cyc < 400) begin
      if (poke && (cyc == az + 2 || cyc == az + INT_TICKS + 1)) start_i = 1'b1;
      else start_i = 1'b0;
      n_az  += az_short_o;
      n_in  += sel_in_o;
      n_ref += sel_ref_o;
      if (done_o) seen = 1;
      else begin
        if (result_o != old_res) check("R8 result held mid-run", result_o, old_res);
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0;
    if (!seen) check("R8 done reached", 0, 1);
    check("R3 auto-zero length", n_az, az);
    check("R4 integrate length", n_in, INT_TICKS);
    check("R6 result", result_o, e);
    check("R7 overrange flag", ovr_o, e_ov);
    check("R5 reference cycles", n_ref, e + 1);
    check("R10 busy in done cycle", busy_o, 1);
    @(negedge clk);
    check("R8 done one cycle", done_o, 0);
    check("R10 idle after done", busy_o, 0);
    repeat (2) @(negedge clk);
    check("R8 result held after done", result_o, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 switches in reset", {az_short_o, sel_in_o, sel_ref_o}, 0);
    check("R1 status in reset", {busy_o, done_o, ovr_o}, 0);
    check("R1 result in reset", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busy_o, done_o, result_o}, 0);
    for (int az = 0; az < 4; az++)
      for (int v = 0; v < 10; v++)
        convert(v, (az == 3) ? 7 : az, 1'b0);
    // start pulses during integrate and discharge must be ignored (R2)
    convert(3, 2, 1'b1);
    convert(9, 0, 1'b1);
    convert(5, 1, 1'b1);
    // R9 switch exclusivity observed across one more run
    convert(2, 3, 1'b0);
    check("R9 idle switches", {az_short_o, sel_in_o, sel_ref_o}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule